// File: doc/BRIEF.md
# Flash Write Status Reporter

This block models the status behaviour of a parallel NOR flash while its internal program and erase algorithms run. A host issues a one-cycle program strobe (address and data) or an erase strobe (a sector-select mask). The block then runs a cycle-counted busy window and updates a small internal byte array at the end of that window. Each sector's protection comes from an input map.

While an algorithm runs, any read returns a status byte instead of array data. Bit 7 is the polling bit, bit 6 is the toggle bit, bit 5 is the error bit, and bits 4..0 read zero. Program and erase refuse to act on protected sectors, but they still hold the block busy for a short, separately parameterised window. A hardware reset cancels any running operation. The host watches the ready output, or polls the status bits, to learn when the array is readable again.

Top module: `flash_wstat`

## Requirements
- R1: While `rst_n` is low, `ready` is 1 and `rdata` is 0x00. A reset during a program abandons it, and the target byte keeps its old value.
- R2: When `prog_stb` is accepted, `ready` is 0 for exactly PROG_CYC cycles after the accepting edge and then returns to 1. With no strobe, an idle block stays ready.
- R3: A completed program stores the old byte AND the written byte, so a bit can only fall from 1 to 0.
- R4: A status read during a program returns bit 7 as the inverse of bit 7 of the written byte, and bits 4..0 as zero.
- R5: Status bit 5 reads 1 during a program that tries to raise any stored 0 to 1, and 0 otherwise.
- R6: On two back-to-back status reads during a busy window, bit 6 holds opposite values, whatever addresses are read.
- R7: When `erase_stb` is accepted, `ready` is 0 for ERASE_CYC cycles, and status bit 7 reads 0. At the end, every byte of each selected, unprotected sector becomes 0xFF, and other sectors are unchanged.
- R8: A program to a protected sector holds `ready` low for PROT_PROG_CYC cycles and leaves the array unchanged.
- R9: An erase whose selected sectors are all protected holds `ready` low for PROT_ERASE_CYC cycles and changes nothing.
- R10: Program and erase strobes that arrive while `ready` is 0 are ignored.
- R11: A read while idle returns the stored byte on `rdata` one cycle after `rd_stb`. The sector is the top SECT_BITS bits of `addr`. If both strobes come in the same cycle, program wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous |
| addr | input | ADDR_W | Byte address for read or program |
| wdata | input | 8 | Byte to program |
| rd_stb | input | 1 | Read request |
| prog_stb | input | 1 | Final program command cycle |
| erase_stb | input | 1 | Final erase command cycle |
| erase_sel | input | 2**SECT_BITS | Sectors selected for erase |
| prot_map | input | 2**SECT_BITS | Sector protection, 1 = protected |
| rdata | output | 8 | Array data or status byte |
| ready | output | 1 | 1 = idle, 0 = algorithm running |

## Verification
The checker enforces the following on every cycle:
- an accepted strobe drops `ready`;
- an idle block stays ready;
- reset forces ready;
- status reads carry the correct polling bit for the operation in flight;
- back-to-back status reads flip the toggle bit.

The array contents after completion can only be seen through the bench's scenarios:
- AND-only programming;
- erase of only the unprotected selected sectors;
- protected no-ops;
- data kept across an aborting reset.

The exact busy lengths are also shown only by those scenarios.

// File: rtl/flash_wstat.sv
module flash_wstat #(
  parameter int ADDR_W         = 6,
  parameter int SECT_BITS      = 2,
  parameter int PROG_CYC       = 6,
  parameter int ERASE_CYC      = 20,
  parameter int PROT_PROG_CYC  = 3,
  parameter int PROT_ERASE_CYC = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [7:0]                wdata,
  input  logic                      rd_stb,
  input  logic                      prog_stb,
  input  logic                      erase_stb,
  input  logic [(1<<SECT_BITS)-1:0] erase_sel,
  input  logic [(1<<SECT_BITS)-1:0] prot_map,
  output logic [7:0]                rdata,
  output logic                      ready
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NSECT = 1 << SECT_BITS;
  localparam int MAX_A = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_B = (PROT_PROG_CYC > PROT_ERASE_CYC) ? PROT_PROG_CYC : PROT_ERASE_CYC;
  localparam int MAXC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAXC + 1);

  logic [7:0]        mem [DEPTH];
  logic              busy, op_erase, pwr, err, tog;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] paddr;
  logic [7:0]        pdata;
  logic [NSECT-1:0]  emask;

  wire [SECT_BITS-1:0] sect     = addr[ADDR_W-1 -: SECT_BITS];
  wire                 prog_go  = prog_stb & ~busy;
  wire                 erase_go = erase_stb & ~prog_stb & ~busy;
  wire                 prot_hit = prot_map[sect];
  wire [NSECT-1:0]     eff_sel  = erase_sel & ~prot_map;
  wire                 fin      = busy && (cnt == CNT_W'(1));

  assign ready = ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op_erase <= 1'b0;
      pwr      <= 1'b0;
      err      <= 1'b0;
      cnt      <= '0;
      paddr    <= '0;
      pdata    <= '0;
      emask    <= '0;
    end else if (prog_go) begin
      busy     <= 1'b1;
      op_erase <= 1'b0;
      pwr      <= ~prot_hit;
      err      <= ~prot_hit && (|(wdata & ~mem[addr]));
      cnt      <= prot_hit ? CNT_W'(PROT_PROG_CYC) : CNT_W'(PROG_CYC);
      paddr    <= addr;
      pdata    <= wdata;
    end else if (erase_go) begin
      busy     <= 1'b1;
      op_erase <= 1'b1;
      err      <= 1'b0;
      emask    <= eff_sel;
      cnt      <= (eff_sel == '0) ? CNT_W'(PROT_ERASE_CYC) : CNT_W'(ERASE_CYC);
    end else if (busy) begin
      cnt <= cnt - 1'b1;
      if (fin) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fin) begin
      if (op_erase) begin
        for (int i = 0; i < DEPTH; i++)
          if (emask[i[ADDR_W-1 -: SECT_BITS]]) mem[i[ADDR_W-1:0]] <= 8'hFF;
      end else if (pwr) begin
        mem[paddr] <= mem[paddr] & pdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
      tog   <= 1'b0;
    end else if (rd_stb) begin
      if (busy) begin
        rdata <= {op_erase ? 1'b0 : ~pdata[7], tog, err, 5'b0};
        tog   <= ~tog;
      end else begin
        rdata <= mem[addr];
      end
    end
  end
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rd_stb,
  input logic       prog_stb,
  input logic       erase_stb,
  input logic       ready,
  input logic [7:0] rdata,
  input logic       op_erase,
  input logic       pbit7
);
  AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_stb && ready) |=> !ready); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !prog_stb && !erase_stb) |=> ready); // R2
  AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_stb && !prog_stb && ready) |=> !ready); // R7
  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ready && op_erase) |=> (rdata[7] == 1'b0 && rdata[4:0] == 5'b0)); // R7
  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ready && !op_erase) |=> (rdata[7] == !$past(pbit7) && rdata[4:0] == 5'b0)); // R4
  AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !ready && $past(rd_stb && !ready)) |=> (rdata[6] != $past(rdata[6]))); // R6
  AST_RESET_READY: assert property (@(posedge clk)
    !rst_n |=> ready); // R1
endmodule

bind flash_wstat flash_wstat_chk chk_i (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .prog_stb(prog_stb),
  .erase_stb(erase_stb), .ready(ready), .rdata(rdata),
  .op_erase(op_erase), .pbit7(pdata[7])
);

// File: tb/flash_wstat_tb.sv
module flash_wstat_tb_top;
  localparam int ADDR_W = 6, SECT_BITS = 2;
  localparam int PROG_CYC = 6, ERASE_CYC = 20, PROT_PROG_CYC = 3, PROT_ERASE_CYC = 12;
  localparam int NV = 4;
  // {addr, wdata, expected byte, expected error bit}
  localparam logic [22:0] VEC [NV] = '{
    {6'h05, 8'h5A, 8'h5A, 1'b0},
    {6'h05, 8'hF0, 8'h50, 1'b1},
    {6'h12, 8'h3C, 8'h3C, 1'b0},
    {6'h2F, 8'h81, 8'h81, 1'b0}
  };

  logic clk = 0, rst_n = 0, rd_stb = 0, prog_stb = 0, erase_stb = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, s1, s2, d;
  logic [3:0] erase_sel = '0, prot_map = '0;
  logic ready;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  flash_wstat #(.ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS), .PROG_CYC(PROG_CYC),
    .ERASE_CYC(ERASE_CYC), .PROT_PROG_CYC(PROT_PROG_CYC), .PROT_ERASE_CYC(PROT_ERASE_CYC))
  dut_i (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_stb(rd_stb),
    .prog_stb(prog_stb), .erase_stb(erase_stb), .erase_sel(erase_sel),
    .prot_map(prot_map), .rdata(rdata), .ready(ready));

  task automatic cyc(); @(negedge clk); endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic prog(logic [ADDR_W-1:0] a, logic [7:0] v);
    addr = a; wdata = v; prog_stb = 1; cyc(); prog_stb = 0;
  endtask

  task automatic erase(logic [3:0] sel);
    erase_sel = sel; erase_stb = 1; cyc(); erase_stb = 0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [7:0] v);
    addr = a; rd_stb = 1; cyc(); rd_stb = 0; v = rdata;
  endtask

  task automatic wait_ready();
    for (int k = 0; k < 200 && !ready; k++) cyc();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk("R1 ready in reset", {7'b0, ready}, 8'h01);
    chk("R1 rdata in reset", rdata, 8'h00);
    rst_n = 1; cyc();

    // R7 erase all, R6 toggle at two addresses
    erase(4'hF);
    rd(6'h07, s1); rd(6'h33, s2);
    chk("R7 erase poll bit7", {7'b0, s1[7]}, 8'h00);
    chk("R7 erase low bits", {3'b0, s2[4:0]}, 8'h00);
    chk("R6 toggle flips", {7'b0, s1[6] ^ s2[6]}, 8'h01);
    repeat (ERASE_CYC - 3) cyc();
    chk("R7 busy before end", {7'b0, ready}, 8'h00);
    cyc();
    chk("R7 ready at end", {7'b0, ready}, 8'h01);
    rd(6'h00, d); chk("R7 erased low", d, 8'hFF);
    rd(6'h3F, d); chk("R11 erased high", d, 8'hFF);

    // R2 exact program length
    prog(6'h30, 8'h77);
    repeat (PROG_CYC - 1) cyc();
    chk("R2 busy before end", {7'b0, ready}, 8'h00);
    cyc();
    chk("R2 ready at end", {7'b0, ready}, 8'h01);
    rd(6'h30, d); chk("R3 program 0x30", d, 8'h77);

    for (int i = 0; i < NV; i++) begin
      prog(VEC[i][22:17], VEC[i][16:9]);
      rd(VEC[i][22:17], s1);
      chk("R4 poll bit7", {7'b0, s1[7]}, {7'b0, ~VEC[i][16]});
      chk("R4 low bits", {3'b0, s1[4:0]}, 8'h00);
      chk("R5 error bit", {7'b0, s1[5]}, {7'b0, VEC[i][0]});
      wait_ready();
      rd(VEC[i][22:17], d);
      chk("R3 stored byte", d, VEC[i][8:1]);
    end

    // R10 erase strobe during program ignored
    prog(6'h3A, 8'hEE);
    erase(4'hF);
    wait_ready();
    rd(6'h05, d); chk("R10 no erase 0x05", d, 8'h50);
    rd(6'h3A, d); chk("R10 program kept", d, 8'hEE);

    // R7 partial protection: sector0 protected, sectors 0 and 1 selected
    prot_map = 4'b0001;
    erase(4'b0011);
    wait_ready();
    rd(6'h05, d); chk("R7 protected sector kept", d, 8'h50);
    rd(6'h12, d); chk("R7 unprotected erased", d, 8'hFF);
    rd(6'h2F, d); chk("R7 unselected kept", d, 8'h81);

    // R9 all-protected erase
    prot_map = 4'b0100;
    erase(4'b0100);
    repeat (PROT_ERASE_CYC - 1) cyc();
    chk("R9 busy before end", {7'b0, ready}, 8'h00);
    cyc();
    chk("R9 ready at end", {7'b0, ready}, 8'h01);
    rd(6'h2F, d); chk("R9 data unchanged", d, 8'h81);

    // R8 protected program
    prot_map = 4'b0001;
    prog(6'h05, 8'h00);
    repeat (PROT_PROG_CYC - 1) cyc();
    chk("R8 busy before end", {7'b0, ready}, 8'h00);
    cyc();
    chk("R8 ready at end", {7'b0, ready}, 8'h01);
    rd(6'h05, d); chk("R8 data unchanged", d, 8'h50);
    prot_map = 4'b0000;

    // R1 reset aborts program
    prog(6'h30, 8'h00);
    cyc();
    rst_n = 0; cyc();
    chk("R1 abort ready", {7'b0, ready}, 8'h01);
    rst_n = 1; cyc();
    rd(6'h30, d); chk("R1 abort keeps data", d, 8'h77);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule